// File: doc/BRIEF.md
# Vector Condition-Field Branch Reducer

This block turns a vector of per-element condition tests into one branch decision. A condition register file holds 128 fields of four bits each. A short bit selector picks one bit position inside a field and adds a small offset to the field index. The block then reads that bit from a run of consecutive fields in vector mode, or from a single field in scalar mode. Each element can be excluded by a predicate mask. The bits that remain are combined with AND or with OR. An invert control complements the result, which gives NAND and NOR.

A start pulse latches the configuration. The block then steps through the elements at one per clock and reports the outcome with a single-cycle valid strobe. The branch can only go one way, so the walk ends as soon as the outcome is certain: at the first active 0 under AND, or the first active 1 under OR. The reported value is always the same as a full walk would give.

Top module: `cfvec_branch_reduce`

## Requirements
- R1: After reset, `valid_o` and `taken_o` are both 0.
- R2: Field f occupies `cr_i[4f+3:4f]`. `bit_sel_i[1:0]` selects bit b of a field, and the tested bit is `cr_i[4f+b]`. `bit_sel_i[4:2]` is an offset that is added to the field index.
- R3: In vector mode (`scalar_i`=1'b0), element i tests field (`start_fld_i` + offset + i) mod 128. In scalar mode (`scalar_i`=1'b1), every element tests field (`start_fld_i` + offset) mod 128.
- R4: With `or_mode_i`=0 the result is the AND of the tested bits of all active elements. With `or_mode_i`=1 it is their OR.
- R5: With `invert_i`=1, `taken_o` is the complement of the AND/OR result, which gives NAND/NOR.
- R6: An element i with `mask_i[i]`=0 does not affect the result and does not end the walk early.
- R7: When `vl_i`=0, or every element is masked out, the result is the identity of the reduction (1 for AND, 0 for OR), with the inversion then applied.
- R8: The rising edge that samples `start_i` counts as edge 1. With `vl_i`=0, `valid_o` is high after edge 1. Otherwise, if no early decision occurs, it is high after edge `vl_i`+1. It stays high for exactly one cycle. `taken_o` changes only in a cycle where `valid_o` is high.
- R9: If the first active element whose bit equals the absorbing value (0 for AND, 1 for OR) has index k, `valid_o` is high after edge k+2. The result equals that of a full walk.
- R10: A `start_i` pulse during a walk is ignored: the running result and its timing are unchanged.
- R11: A `start_i` pulse in the same cycle that `valid_o` is high is accepted and begins a new evaluation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cr_i | input | 512 | Condition register file, 128 fields of 4 bits; must stay stable during a walk |
| bit_sel_i | input | 5 | [1:0] bit within the field, [4:2] field offset |
| start_fld_i | input | 7 | Base field index |
| vl_i | input | 7 | Vector length, 0..64 (larger values clamp to 64) |
| mask_i | input | 64 | Per-element predicate, bit i enables element i |
| scalar_i | input | 1 | 1: all elements test the same field |
| or_mode_i | input | 1 | 0: AND reduction, 1: OR reduction |
| invert_i | input | 1 | Complement the reduced result |
| start_i | input | 1 | Begin an evaluation (only while idle or at valid) |
| taken_o | output | 1 | Branch decision, meaningful while valid_o is high |
| valid_o | output | 1 | One-cycle strobe marking a new decision |

## Verification
The stimulus targets the empty cases: zero length, and a mask that removes every element. A design that does not fall back to the reduction identity returns the wrong polarity or never raises valid in these cases. Field indices that wrap past 127 are tested, along with single bits placed at a chosen field and bit position, so a wrong offset add or bit ordering shows up as a wrong decision. An absorbing value placed on a masked-out element must not stop the walk, and an absorbing value on an active element must stop it at exactly index plus two edges. A start pulse issued during a walk and a start issued alongside valid check that the sequencer neither restarts nor drops a request.

// File: rtl/cfr_pkg.sv
package cfr_pkg;

    typedef enum logic {
        RED_AND = 1'b0,
        RED_OR  = 1'b1
    } red_mode_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WALK = 1'b1
    } walk_st_e;

    // Value that leaves the reduction unchanged
    function automatic logic red_identity(red_mode_e m);
        return (m == RED_AND);
    endfunction

    // Value that fixes the reduction outcome once seen
    function automatic logic red_absorb(red_mode_e m);
        return (m == RED_OR);
    endfunction

endpackage

// File: rtl/cfr_field_pick.sv
module cfr_field_pick #(
    parameter int NUM_FIELDS = 128,
    parameter int FIELD_W    = 4,
    localparam int FIDX_W    = $clog2(NUM_FIELDS),
    localparam int BIT_W     = $clog2(FIELD_W),
    localparam int CR_W      = NUM_FIELDS * FIELD_W
) (
    input  logic [CR_W-1:0]   cr_i,
    input  logic [FIDX_W-1:0] fld_i,
    input  logic [BIT_W-1:0]  bit_i,
    output logic              bit_o
);

    logic [FIELD_W-1:0] fields [NUM_FIELDS];

    // Unpack the flat register file into addressable fields
    for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_unpack
        assign fields[f] = cr_i[f*FIELD_W +: FIELD_W];
    end

    logic [FIELD_W-1:0] sel_field;

    always_comb begin
        sel_field = fields[fld_i];
        bit_o     = sel_field[bit_i];
    end

endmodule

// File: rtl/cfr_reduce_step.sv
module cfr_reduce_step
    import cfr_pkg::*;
(
    input  logic      bit_i,
    input  logic      active_i,
    input  red_mode_e mode_i,
    output logic      decided_o
);

    // An active element carrying the absorbing value settles the outcome;
    // an identity value or a masked element leaves it open.
    always_comb begin
        decided_o = active_i && (bit_i == red_absorb(mode_i));
    end

endmodule

// File: rtl/cfr_walk_ctrl.sv
module cfr_walk_ctrl
    import cfr_pkg::*;
#(
    parameter int NUM_FIELDS = 128,
    parameter int FIELD_W    = 4,
    parameter int MAX_VL     = 64,
    parameter int BSEL_W     = 5,
    localparam int FIDX_W    = $clog2(NUM_FIELDS),
    localparam int BIT_W     = $clog2(FIELD_W),
    localparam int OFF_W     = BSEL_W - BIT_W,
    localparam int VL_W      = $clog2(MAX_VL + 1),
    localparam int EIDX_W    = (MAX_VL > 1) ? $clog2(MAX_VL) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [VL_W-1:0]   vl_i,
    input  logic [MAX_VL-1:0] mask_i,
    input  logic [FIDX_W-1:0] start_fld_i,
    input  logic [BSEL_W-1:0] bit_sel_i,
    input  logic              scalar_i,
    input  red_mode_e         mode_i,
    input  logic              inv_i,
    input  logic              decided_i,
    output logic [FIDX_W-1:0] fld_addr_o,
    output logic [BIT_W-1:0]  bit_idx_o,
    output logic              elem_active_o,
    output red_mode_e         mode_o,
    output logic              valid_o,
    output logic              taken_o
);

    localparam logic [VL_W-1:0] VL_CAP = VL_W'(MAX_VL);

    typedef struct packed {
        logic [VL_W-1:0]   vl;
        logic [MAX_VL-1:0] mask;
        logic [FIDX_W-1:0] base;
        logic [BIT_W-1:0]  bidx;
        logic              scal;
        red_mode_e         mode;
        logic              inv;
    } cfg_t;

    typedef struct packed {
        walk_st_e        st;
        logic [VL_W-1:0] eidx;
        cfg_t            cfg;
        logic            valid;
        logic            taken;
    } ctl_t;

    ctl_t d, q;
    logic fin;
    logic last;
    logic [OFF_W-1:0] off;

    always_comb begin
        d    = q;
        fin  = 1'b0;
        last = 1'b0;
        off  = bit_sel_i[BSEL_W-1:BIT_W];
        d.valid = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (start_i) begin
                    d.cfg.vl   = (vl_i > VL_CAP) ? VL_CAP : vl_i;
                    d.cfg.mask = mask_i;
                    d.cfg.base = start_fld_i + FIDX_W'(off);
                    d.cfg.bidx = bit_sel_i[BIT_W-1:0];
                    d.cfg.scal = scalar_i;
                    d.cfg.mode = mode_i;
                    d.cfg.inv  = inv_i;
                    d.eidx     = '0;
                    if (vl_i == '0) begin
                        d.valid = 1'b1;
                        d.taken = red_identity(mode_i) ^ inv_i;
                    end else begin
                        d.st = ST_WALK;
                    end
                end
            end
            ST_WALK: begin
                last = ((q.eidx + 1'b1) == q.cfg.vl);
                fin  = decided_i || last;
                if (fin) begin
                    d.st    = ST_IDLE;
                    d.valid = 1'b1;
                    d.taken = (decided_i ? red_absorb(q.cfg.mode)
                                         : red_identity(q.cfg.mode)) ^ q.cfg.inv;
                end else begin
                    d.eidx = q.eidx + 1'b1;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        fld_addr_o    = q.cfg.base + (q.cfg.scal ? '0 : FIDX_W'(q.eidx));
        bit_idx_o     = q.cfg.bidx;
        elem_active_o = (q.st == ST_WALK) && q.cfg.mask[q.eidx[EIDX_W-1:0]];
        mode_o        = q.cfg.mode;
        valid_o       = q.valid;
        taken_o       = q.taken;
    end

    // R10: the latched configuration does not move while walking
    p_cfg_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_WALK) |=> $stable(q.cfg));

    // R8: an unfinished walk advances exactly one element per clock
    p_walk_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_WALK && !fin) |=> (q.st == ST_WALK && q.eidx == $past(q.eidx) + 1'b1));

    // R3: the element index never reaches the latched length
    p_eidx_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_WALK) |-> (q.eidx < q.cfg.vl));

    // R8: a strobe only follows a walk or an accepted start
    p_valid_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
        q.valid |-> ($past(q.st) == ST_WALK || $past(start_i)));

    // R9: an absorbing active element ends the walk with the absorbing outcome
    p_early_stop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_WALK && decided_i) |=>
            (q.valid && q.st == ST_IDLE &&
             q.taken == (red_absorb(q.cfg.mode) ^ q.cfg.inv)));

endmodule

// File: rtl/cfvec_branch_reduce.sv
module cfvec_branch_reduce
    import cfr_pkg::*;
#(
    parameter int NUM_FIELDS = 128,
    parameter int FIELD_W    = 4,
    parameter int MAX_VL     = 64,
    parameter int BSEL_W     = 5,
    localparam int FIDX_W    = $clog2(NUM_FIELDS),
    localparam int BIT_W     = $clog2(FIELD_W),
    localparam int VL_W      = $clog2(MAX_VL + 1),
    localparam int CR_W      = NUM_FIELDS * FIELD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CR_W-1:0]   cr_i,
    input  logic [BSEL_W-1:0] bit_sel_i,
    input  logic [FIDX_W-1:0] start_fld_i,
    input  logic [VL_W-1:0]   vl_i,
    input  logic [MAX_VL-1:0] mask_i,
    input  logic              scalar_i,
    input  logic              or_mode_i,
    input  logic              invert_i,
    input  logic              start_i,
    output logic              taken_o,
    output logic              valid_o
);

    logic [FIDX_W-1:0] fld_addr;
    logic [BIT_W-1:0]  bit_idx;
    logic              elem_active;
    logic              cur_bit;
    logic              decided;
    red_mode_e         mode_cur;

    cfr_walk_ctrl #(
        .NUM_FIELDS (NUM_FIELDS),
        .FIELD_W    (FIELD_W),
        .MAX_VL     (MAX_VL),
        .BSEL_W     (BSEL_W)
    ) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_i       (start_i),
        .vl_i          (vl_i),
        .mask_i        (mask_i),
        .start_fld_i   (start_fld_i),
        .bit_sel_i     (bit_sel_i),
        .scalar_i      (scalar_i),
        .mode_i        (red_mode_e'(or_mode_i)),
        .inv_i         (invert_i),
        .decided_i     (decided),
        .fld_addr_o    (fld_addr),
        .bit_idx_o     (bit_idx),
        .elem_active_o (elem_active),
        .mode_o        (mode_cur),
        .valid_o       (valid_o),
        .taken_o       (taken_o)
    );

    cfr_field_pick #(
        .NUM_FIELDS (NUM_FIELDS),
        .FIELD_W    (FIELD_W)
    ) u_pick (
        .cr_i  (cr_i),
        .fld_i (fld_addr),
        .bit_i (bit_idx),
        .bit_o (cur_bit)
    );

    cfr_reduce_step u_step (
        .bit_i     (cur_bit),
        .active_i  (elem_active),
        .mode_i    (mode_cur),
        .decided_o (decided)
    );

    // R8: the decision output holds between strobes
    p_taken_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> $stable(taken_o));

    // R6: a masked element never settles the outcome
    p_masked_inert_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !elem_active |-> !decided);

endmodule

// File: tb/tb_cfvec_branch_reduce.sv
module tb_cfvec_branch_reduce;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [511:0] cr_i = '0;
    logic [4:0]   bit_sel_i = '0;
    logic [6:0]   start_fld_i = '0;
    logic [6:0]   vl_i = '0;
    logic [63:0]  mask_i = '0;
    logic         scalar_i = 1'b0;
    logic         or_mode_i = 1'b0;
    logic         invert_i = 1'b0;
    logic         start_i = 1'b0;
    logic         taken_o;
    logic         valid_o;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    // bench-side configuration
    logic [511:0] c_cr;
    logic [4:0]   c_bsel;
    logic [6:0]   c_sf;
    int           c_vl;
    logic [63:0]  c_mask;
    logic         c_scal, c_or, c_inv;

    cfvec_branch_reduce dut (
        .clk(clk), .rst_n(rst_n), .cr_i(cr_i), .bit_sel_i(bit_sel_i),
        .start_fld_i(start_fld_i), .vl_i(vl_i), .mask_i(mask_i),
        .scalar_i(scalar_i), .or_mode_i(or_mode_i), .invert_i(invert_i),
        .start_i(start_i), .taken_o(taken_o), .valid_o(valid_o)
    );

    always #10 clk = ~clk;

    task automatic check(string tag, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // full-walk reference: result and strobe latency in edges
    function automatic void ref_eval(output logic taken, output int lat);
        logic acc;
        int   k;
        acc = !c_or;
        k = -1;
        for (int i = 0; i < c_vl; i++) begin
            int  fld;
            logic b;
            fld = (int'(c_sf) + int'(c_bsel[4:2]) + (c_scal ? 0 : i)) % 128;
            b = c_cr[fld*4 + int'(c_bsel[1:0])];
            if (c_mask[i]) begin
                if (c_or) acc = acc | b; else acc = acc & b;
                if (k < 0 && b == c_or) k = i;
            end
        end
        taken = acc ^ c_inv;
        if (c_vl == 0)   lat = 1;
        else if (k >= 0) lat = k + 2;
        else             lat = c_vl + 1;
    endfunction

    // drive config and raise start (called right after a negedge)
    task automatic launch();
        cr_i        = c_cr;
        bit_sel_i   = c_bsel;
        start_fld_i = c_sf;
        vl_i        = 7'(c_vl);
        mask_i      = c_mask;
        scalar_i    = c_scal;
        or_mode_i   = c_or;
        invert_i    = c_inv;
        start_i     = 1'b1;
    endtask

    task automatic wait_result(string tag, bit disturb);
        logic et;
        int   el;
        int   lat;
        bit   seen;
        ref_eval(et, el);
        seen = 1'b0;
        lat = 0;
        while (!seen && lat < 200) begin
            @(negedge clk);
            lat++;
            start_i = 1'b0;
            if (disturb && lat == 2 && el >= 4) begin
                start_i     = 1'b1;
                bit_sel_i   = ~c_bsel;
                start_fld_i = ~c_sf;
                vl_i        = 7'd1;
                mask_i      = ~c_mask;
                scalar_i    = ~c_scal;
                or_mode_i   = ~c_or;
                invert_i    = ~c_inv;
            end
            if (valid_o) seen = 1'b1;
        end
        check({tag, " latency"}, seen ? lat : -1, el);
        check({tag, " taken"}, int'(taken_o), int'(et));
    endtask

    task automatic pulse_check(string tag);
        @(negedge clk);
        check({tag, " valid one cycle"}, int'(valid_o), 0);
    endtask

    task automatic clear_cfg();
        c_cr = '0; c_bsel = '0; c_sf = '0; c_vl = 0; c_mask = '1;
        c_scal = 1'b0; c_or = 1'b0; c_inv = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_c0de));
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 valid", int'(valid_o), 0);
        check("R1 taken", int'(taken_o), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R7: empty vector, AND identity / OR identity inverted
        clear_cfg(); c_vl = 0;
        launch(); wait_result("R7 vl0 and", 0); pulse_check("R8");
        c_or = 1'b1; c_inv = 1'b1;
        launch(); wait_result("R7 R5 vl0 nor", 0); pulse_check("R8");

        // R6 R7: all masked, OR -> 0 over full length
        clear_cfg(); c_cr = '1; c_or = 1'b1; c_vl = 10; c_mask = '0;
        launch(); wait_result("R6 R7 all masked", 0); pulse_check("R8");

        // R2: single bit at field 5 bit 2 via base 3 + offset 2
        clear_cfg(); c_cr[5*4 + 2] = 1'b1; c_scal = 1'b1; c_sf = 7'd3;
        c_bsel = {3'd2, 2'd2}; c_vl = 1; c_or = 1'b1;
        launch(); wait_result("R2 bit hit", 0); pulse_check("R8");
        c_bsel = {3'd2, 2'd1};
        launch(); wait_result("R2 neighbour bit", 0); pulse_check("R8");

        // R3: vector wrap 126,127,0,1 -- only field 1 bit0 set
        clear_cfg(); c_cr[1*4] = 1'b1; c_sf = 7'd126; c_vl = 4; c_or = 1'b1;
        c_mask = 64'h8;
        launch(); wait_result("R3 wrap hit", 0); pulse_check("R8");
        c_mask = 64'h4;
        launch(); wait_result("R3 wrap miss", 0); pulse_check("R8");
        // R3: scalar mode repeats one field
        c_scal = 1'b1; c_sf = 7'd1; c_mask = 64'h8;
        launch(); wait_result("R3 scalar", 0); pulse_check("R8");

        // R4 R8: full AND walk of 64 ones
        clear_cfg(); c_cr = '1; c_vl = 64;
        launch(); wait_result("R4 R8 full and", 0); pulse_check("R8");

        // R9 R5: early exit at element 5, then NAND
        clear_cfg(); c_cr = '1; c_vl = 20; c_cr[(5+2)*4] = 1'b0; c_sf = 7'd2;
        launch(); wait_result("R9 early and", 0); pulse_check("R8");
        c_inv = 1'b1;
        launch(); wait_result("R9 R5 nand", 0); pulse_check("R8");

        // R6: absorbing value on a masked element does not stop the walk
        c_inv = 1'b0; c_mask = ~64'h20;
        launch(); wait_result("R6 masked zero", 0); pulse_check("R8");

        // R10: start during a walk is ignored
        clear_cfg(); c_cr = '1; c_vl = 30;
        launch(); wait_result("R10 ignore start", 1);
        start_i = 1'b0;
        pulse_check("R10");

        // R11: start alongside valid is accepted
        clear_cfg(); c_cr = '1; c_vl = 3;
        launch(); wait_result("R11 first", 0);
        c_or = 1'b1; c_cr = '0; c_vl = 5;
        launch(); wait_result("R11 chained", 0); pulse_check("R8");

        // Random mix, R4 R5 R6 R9
        for (int t = 0; t < 400; t++) begin
            int dens;
            c_or   = 1'($urandom);
            c_inv  = 1'($urandom);
            c_scal = ($urandom % 4) == 0;
            c_bsel = 5'($urandom);
            c_sf   = 7'($urandom);
            c_vl   = $urandom % 65;
            c_mask = {$urandom, $urandom};
            if ($urandom % 3 == 0) c_mask = '1;
            dens = ($urandom % 4 == 0) ? 50 : (c_or ? 3 : 97);
            for (int b = 0; b < 512; b++) c_cr[b] = ($urandom % 100) < dens;
            launch();
            wait_result("R4 R5 R6 R9 random", (t % 7) == 0);
            start_i = 1'b0;
            pulse_check("R8");
        end

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule